// File: doc/BRIEF.md
# Speculation Check Recovery Redirect Unit

This unit finishes handling a speculation check fault that the hardware could not resolve by branching. The fault handler pulses `start` and supplies the kind of check that faulted, the check's 21-bit immediate, the interrupted bundle address, the excepting slot, the no-instruction flag and the two pending trap enables. The unit saves the interrupted address as the previous address. It forms the recovery target by sign-extending the immediate, scaling it to a 16-byte bundle offset and adding it to the interrupted address. It then clears the slot index.

The unit also chooses where control goes next. With no trap enabled, it returns from the interruption. If a taken-branch trap is pending, that trap takes priority. Otherwise a pending single-step trap applies. For each outcome the unit builds the 64-bit syndrome word that goes with it. A check kind outside the supported set raises an error and leaves the address untouched. The work runs as a short multi-cycle sequence with a busy flag and a one-cycle done pulse.

Top module: `spec_recover_unit`

## Requirements
- R1: The unit accepts `start` only while `busy` is low. `done` is high for exactly one cycle, during the second clock cycle after the accepting edge. A `start` that arrives while `busy` is high is ignored.
- R2: When `done` is high, `prev_ip` equals the `iip_in` value that was latched at start.
- R3: For check kinds 0 to 4, `new_ip` = `iip_in` + (sign-extended `imm` × 16), taken modulo 2^64. A negative immediate gives a lower address, and sums past either end of the address space wrap around.
- R4: For check kinds 0 to 4, `slot_out` is 0 when `done` is high.
- R5: The syndrome word places `slot_in` at bits 42:41 and `ni_in` at bit 39. All other bits above 3 are 0. The `action` encoding is 0 = return, 1 = taken-branch trap, 2 = single-step trap, and value 3 never appears.
- R6: If the kind is 0 to 4 and `tb_en` is 1, then `action` = 1 and `vec_off` = 0x5F00. Syndrome bit 2 is 1, bit 3 equals `ss_en`, and bits 1:0 are 0.
- R7: If the kind is 0 to 4, `tb_en` is 0 and `ss_en` is 1, then `action` = 2 and `vec_off` = 0x6000. Syndrome bits 3:0 equal 4'b1000.
- R8: If the kind is 0 to 4 and neither flag is set, then `action` = 0 and `vec_off` = 0x0000. Syndrome bits 3:0 equal the check kind, coded as 0 = integer advanced, 1 = integer speculative, 2 = float advanced, 3 = float speculative, 4 = float flag check.
- R9: For a check kind of 5 to 15, `err` = 1, `new_ip` = `iip_in`, `slot_out` = `slot_in`, `action` = 0 and `vec_off` = 0x5700. Syndrome bits 3:0 equal the kind, and both trap flags are ignored.
- R10: After reset, `busy`, `done` and `err` are 0, and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a redirect; latches all request inputs |
| chk_kind | input | 4 | Kind of check that faulted |
| imm | input | 21 | Immediate of the check, in bundle units |
| iip_in | input | 64 | Interrupted bundle address |
| slot_in | input | 2 | Excepting slot |
| ni_in | input | 1 | No-instruction flag for the syndrome |
| tb_en | input | 1 | Taken-branch trap pending |
| ss_en | input | 1 | Single-step trap pending |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Unsupported check kind |
| action | output | 2 | Next step: 0 return, 1 taken-branch trap, 2 single-step trap |
| vec_off | output | 16 | Vector offset to branch to |
| new_ip | output | 64 | Redirected instruction address |
| prev_ip | output | 64 | Saved previous address |
| slot_out | output | 2 | Slot index after redirect |
| syndrome | output | 64 | Syndrome word for the chosen vector |

## Verification
A wrong latch or sequencer state shows up at the ports in the same cycle `done` is high. It appears as a missing or doubled pulse, or as results computed from inputs driven after the accepting edge, such as a second `start` issued while busy. A fault in the target path shows in `new_ip`, most clearly for negative immediates and for sums that cross the top or bottom of the address space. A fault in the priority logic shows as the wrong `action`, vector or low syndrome bits for one of the four flag combinations.

// File: rtl/spec_recover_pkg.sv
package spec_recover_pkg;
   typedef enum logic [1:0] {
      ACT_RET     = 2'd0,
      ACT_TBRANCH = 2'd1,
      ACT_SSTEP   = 2'd2
   } act_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_DONE = 2'd2
   } st_e;

   localparam logic [15:0] VEC_NONE  = 16'h0000;
   localparam logic [15:0] VEC_FAULT = 16'h5700;
   localparam logic [15:0] VEC_TB    = 16'h5F00;
   localparam logic [15:0] VEC_SS    = 16'h6000;
   localparam int          KIND_MAX  = 4;
endpackage

// File: rtl/sr_target_calc.sv
module sr_target_calc #(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 21,
   parameter int SHIFT  = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - IMM_W - SHIFT;

   logic [ADDR_W-1:0] offset;

   if (EXT_W < 0) begin : g_bad_width
      $error("sr_target_calc: ADDR_W too small for IMM_W + SHIFT");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("sr_target_calc: SHIFT must be at least 1");
   end

   generate
      if (EXT_W == 0) begin : g_noext
         assign offset = {imm, {SHIFT{1'b0}}};
      end else begin : g_ext
         assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
      end
   endgenerate

   // modulo 2^ADDR_W add
   assign target = base + offset;
endmodule

// File: rtl/sr_trap_sel.sv
module sr_trap_sel
   import spec_recover_pkg::*;
#(
   parameter int KIND_W = 4,
   parameter int SYN_W  = 64,
   parameter int VEC_W  = 16,
   parameter int EI_LSB = 41,
   parameter int NI_BIT = 39,
   parameter int TB_BIT = 2,
   parameter int SS_BIT = 3
) (
   input  logic [KIND_W-1:0] kind,
   input  logic              tb,
   input  logic              ss,
   input  logic [1:0]        slot,
   input  logic              ni,
   output logic              bad_kind,
   output act_e              act,
   output logic [VEC_W-1:0]  vec,
   output logic [SYN_W-1:0]  syn
);
   if (SYN_W < EI_LSB + 2) begin : g_bad_syn
      $error("sr_trap_sel: SYN_W too small for slot field");
   end
   if (VEC_W < 15) begin : g_bad_vec
      $error("sr_trap_sel: VEC_W too small for vector offsets");
   end
   if (KIND_W < 3) begin : g_bad_kind
      $error("sr_trap_sel: KIND_W too small for kinds 0..4");
   end

   assign bad_kind = (int'(kind) > KIND_MAX);

   always_comb begin
      syn                = '0;
      syn[EI_LSB +: 2]   = slot;
      syn[NI_BIT]        = ni;
      if (bad_kind) begin
         act               = ACT_RET;
         vec               = VEC_W'(VEC_FAULT);
         syn[KIND_W-1:0]   = kind;
      end else if (tb) begin
         act               = ACT_TBRANCH;
         vec               = VEC_W'(VEC_TB);
         syn[TB_BIT]       = 1'b1;
         syn[SS_BIT]       = ss;
      end else if (ss) begin
         act               = ACT_SSTEP;
         vec               = VEC_W'(VEC_SS);
         syn[SS_BIT]       = 1'b1;
      end else begin
         act               = ACT_RET;
         vec               = VEC_W'(VEC_NONE);
         syn[KIND_W-1:0]   = kind;
      end
   end
endmodule

// File: rtl/spec_recover_unit.sv
module spec_recover_unit
   import spec_recover_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 21,
   parameter int SHIFT  = 4,
   parameter int KIND_W = 4,
   parameter int VEC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KIND_W-1:0] chk_kind,
   input  logic [IMM_W-1:0]  imm,
   input  logic [ADDR_W-1:0] iip_in,
   input  logic [1:0]        slot_in,
   input  logic              ni_in,
   input  logic              tb_en,
   input  logic              ss_en,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [1:0]        action,
   output logic [VEC_W-1:0]  vec_off,
   output logic [ADDR_W-1:0] new_ip,
   output logic [ADDR_W-1:0] prev_ip,
   output logic [1:0]        slot_out,
   output logic [ADDR_W-1:0] syndrome
);
   st_e               st_q;
   logic [KIND_W-1:0] kind_q;
   logic [IMM_W-1:0]  imm_q;
   logic [ADDR_W-1:0] iip_q;
   logic [1:0]        slot_q;
   logic              ni_q, tb_q, ss_q;

   logic [ADDR_W-1:0] tgt;
   logic              bad_kind;
   act_e              act_c;
   logic [VEC_W-1:0]  vec_c;
   logic [ADDR_W-1:0] syn_c;

   sr_target_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_tgt (
      .base   (iip_q),
      .imm    (imm_q),
      .target (tgt)
   );

   sr_trap_sel #(.KIND_W(KIND_W), .SYN_W(ADDR_W), .VEC_W(VEC_W)) u_sel (
      .kind     (kind_q),
      .tb       (tb_q),
      .ss       (ss_q),
      .slot     (slot_q),
      .ni       (ni_q),
      .bad_kind (bad_kind),
      .act      (act_c),
      .vec      (vec_c),
      .syn      (syn_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= '0;
         imm_q  <= '0;
         iip_q  <= '0;
         slot_q <= '0;
         ni_q   <= 1'b0;
         tb_q   <= 1'b0;
         ss_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_CALC;
               kind_q <= chk_kind;
               imm_q  <= imm;
               iip_q  <= iip_in;
               slot_q <= slot_in;
               ni_q   <= ni_in;
               tb_q   <= tb_en;
               ss_q   <= ss_en;
            end
            ST_CALC: st_q <= ST_DONE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err      <= 1'b0;
         action   <= '0;
         vec_off  <= '0;
         new_ip   <= '0;
         prev_ip  <= '0;
         slot_out <= '0;
         syndrome <= '0;
      end else if (st_q == ST_CALC) begin
         err      <= bad_kind;
         action   <= act_c;
         vec_off  <= vec_c;
         prev_ip  <= iip_q;
         new_ip   <= bad_kind ? iip_q  : tgt;
         slot_out <= bad_kind ? slot_q : 2'b00;
         syndrome <= syn_c;
      end
   end

   assign busy = (st_q != ST_IDLE);
   assign done = (st_q == ST_DONE);
endmodule

// File: rtl/sr_unit_chk.sv
module sr_unit_chk #(
   parameter int ADDR_W = 64,
   parameter int VEC_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [1:0]        action,
   input logic [VEC_W-1:0]  vec_off,
   input logic [ADDR_W-1:0] new_ip,
   input logic [ADDR_W-1:0] prev_ip,
   input logic [1:0]        slot_out,
   input logic [ADDR_W-1:0] syndrome
);
   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));
   // R4
   slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (slot_out == 2'b00));
   // R9
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (new_ip == prev_ip && vec_off == VEC_W'(16'h5700) && action == 2'd0));
   // R6
   tb_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && action == 2'd1) |-> (vec_off == VEC_W'(16'h5F00) && syndrome[2] && syndrome[1:0] == 2'b00));
   // R7
   ss_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && action == 2'd2) |-> (vec_off == VEC_W'(16'h6000) && syndrome[3:0] == 4'b1000));
   // R5
   act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (action != 2'd3));
endmodule

bind spec_recover_unit sr_unit_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .action   (action),
   .vec_off  (vec_off),
   .new_ip   (new_ip),
   .prev_ip  (prev_ip),
   .slot_out (slot_out),
   .syndrome (syndrome)
);

// File: tb/spec_recover_unit_tb.sv
module spec_recover_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  chk_kind = '0;
   logic [20:0] imm = '0;
   logic [63:0] iip_in = '0;
   logic [1:0]  slot_in = '0;
   logic        ni_in = 1'b0, tb_en = 1'b0, ss_en = 1'b0;
   logic        busy, done, err;
   logic [1:0]  action;
   logic [15:0] vec_off;
   logic [63:0] new_ip, prev_ip, syndrome;
   logic [1:0]  slot_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   spec_recover_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .chk_kind(chk_kind), .imm(imm),
      .iip_in(iip_in), .slot_in(slot_in), .ni_in(ni_in), .tb_en(tb_en), .ss_en(ss_en),
      .busy(busy), .done(done), .err(err), .action(action), .vec_off(vec_off),
      .new_ip(new_ip), .prev_ip(prev_ip), .slot_out(slot_out), .syndrome(syndrome)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] k, input logic [20:0] im, input logic [63:0] ip,
                        input logic [1:0] sl, input logic n, input logic t, input logic s);
      @(negedge clk);
      chk_kind = k; imm = im; iip_in = ip; slot_in = sl; ni_in = n; tb_en = t; ss_en = s;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic expect_result(input logic [3:0] k, input logic [20:0] im, input logic [63:0] ip,
                                input logic [1:0] sl, input logic n, input logic t, input logic s);
      logic [63:0] off, e_ip, e_syn;
      logic        e_err;
      logic [1:0]  e_act, e_slot;
      logic [15:0] e_vec;
      off   = 64'($signed(im)) * 64'd16;
      e_err = (k > 4'd4);
      e_syn = 64'd0;
      e_syn[42:41] = sl;
      e_syn[39]    = n;
      if (e_err) begin
         e_act = 2'd0; e_vec = 16'h5700; e_syn[3:0] = k;
      end else if (t) begin
         e_act = 2'd1; e_vec = 16'h5F00; e_syn[2] = 1'b1; e_syn[3] = s;
      end else if (s) begin
         e_act = 2'd2; e_vec = 16'h6000; e_syn[3] = 1'b1;
      end else begin
         e_act = 2'd0; e_vec = 16'h0000; e_syn[3:0] = k;
      end
      e_ip   = e_err ? ip : ip + off;
      e_slot = e_err ? sl : 2'b00;
      // now at negedge one cycle after accepting edge; done follows next edge
      check("R1", "done early", 64'(done), 64'd0);
      check("R1", "busy", 64'(busy), 64'd1);
      @(negedge clk);
      check("R1", "done", 64'(done), 64'd1);
      check(e_err ? "R9" : "R3", "new_ip", new_ip, e_ip);
      check("R2", "prev_ip", prev_ip, ip);
      check(e_err ? "R9" : "R4", "slot_out", 64'(slot_out), 64'(e_slot));
      check(e_err ? "R9" : "R10", "err", 64'(err), 64'(e_err));
      check(t ? "R6" : (s ? "R7" : "R8"), "action", 64'(action), 64'(e_act));
      check(t ? "R6" : (s ? "R7" : "R8"), "vec_off", 64'(vec_off), 64'(e_vec));
      check("R5", "syndrome", syndrome, e_syn);
      @(negedge clk);
      check("R1", "done one cycle", 64'(done), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [63:0] ips [5];
      logic [20:0] ims [5];
      ips[0] = 64'h0000_0000_0001_0000; ims[0] = 21'h00010;
      ips[1] = 64'h0000_0000_4000_0000; ims[1] = 21'h1FFFF0;
      ips[2] = 64'hFFFF_FFFF_FFFF_FFF0; ims[2] = 21'h000001;
      ips[3] = 64'h0000_0000_0000_0010; ims[3] = 21'h100000;
      ips[4] = 64'h1234_5678_9ABC_DEF0; ims[4] = 21'h0FFFFF;

      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "busy", 64'(busy), 64'd0);
      check("R10", "done", 64'(done), 64'd0);
      check("R10", "err", 64'(err), 64'd0);
      check("R10", "new_ip", new_ip, 64'd0);
      check("R10", "syndrome", syndrome, 64'd0);
      rst_n = 1'b1;

      for (int p = 0; p < 5; p++) begin
         for (int k = 0; k < 16; k++) begin
            for (int f = 0; f < 4; f++) begin
               issue(4'(k), ims[p], ips[p], 2'(p), 1'(p), f[1], f[0]);
               expect_result(4'(k), ims[p], ips[p], 2'(p), 1'(p), f[1], f[0]);
            end
         end
      end

      // R3 backward target and wrap at both ends
      issue(4'd1, 21'h1FFFF0, 64'h0000_0000_4000_0000, 2'd2, 1'b0, 1'b0, 1'b0);
      expect_result(4'd1, 21'h1FFFF0, 64'h0000_0000_4000_0000, 2'd2, 1'b0, 1'b0, 1'b0);
      check("R3", "backward", 64'(new_ip < prev_ip), 64'd1);
      issue(4'd0, 21'h000001, 64'hFFFF_FFFF_FFFF_FFF0, 2'd0, 1'b0, 1'b0, 1'b0);
      expect_result(4'd0, 21'h000001, 64'hFFFF_FFFF_FFFF_FFF0, 2'd0, 1'b0, 1'b0, 1'b0);
      check("R3", "wrap top", new_ip, 64'd0);

      // R1 start while busy is ignored
      issue(4'd2, 21'h00020, 64'h0000_0000_0000_1000, 2'd1, 1'b0, 1'b0, 1'b1);
      chk_kind = 4'd3; imm = 21'h00100; iip_in = 64'h0000_0000_0000_9000; tb_en = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1", "done", 64'(done), 64'd1);
      check("R1", "ignored start new_ip", new_ip, 64'h0000_0000_0000_1200);
      check("R1", "ignored start action", 64'(action), 64'd2);
      @(negedge clk);
      check("R1", "no second done", 64'(done), 64'd0);
      @(negedge clk);
      check("R1", "stays idle", 64'(busy), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule